// File: doc/BRIEF.md
# TPM Interface Register File

This block holds the host-visible register space of a TPM interface and answers a host bus controller through a byte-wide, four-signal handshake on a shared bidirectional data bus. It runs on the host bus clock and every register value is ready within one cycle, so reads and writes never need wait states. A 16-bit address is split into a locality number in the top four bits and a register offset in the low twelve bits.

The block tracks which locality is active. A locality asks for use by writing its access register, and gives up use the same way. When no locality is active, the highest-numbered pending request is granted. The block also holds the interrupt enable, interrupt vector and interrupt status registers. It drives an interrupt level and an IRQ number toward the serial interrupt logic. Any offset it does not define reads as 0xFF and ignores writes. This includes the status and data FIFO offsets, which belong to a later command engine.

The handshake follows valid/ready rules. Each request is a valid. Write-done or read-valid is the ready, and it answers one cycle later. The host holds its strobe and address until that answer arrives, and it drops the strobe to end the transfer. The block drops its answer one cycle after that. The block applies no other back-pressure.

Top module: `tpmrf_top`

## Requirements
- R1: After reset no locality is active and no request is pending. Interrupt enables, global enable, vector and status are zero. `wr_done_o`, `rd_valid_o`, `irq_o` and `irq_num_o` are low, and the data bus is not driven.
- R2: `rd_valid_o` is high in each cycle that follows a cycle with `rd_req_i` high, and low otherwise. The block drives the data bus only while `rd_req_i` and `rd_valid_o` are high and `wr_stb_i` is low. While it drives, the bus carries the byte at `addr_i`.
- R3: `wr_done_o` is high in each cycle that follows a cycle with `wr_stb_i` high, and low otherwise. A write takes effect exactly once per strobe, in the first cycle of that strobe.
- R4: An address reads 0xFF and a write to it has no effect if its locality field (bits 15:12) is 5 or more, or if its offset is not one of 0x000, 0x008-0x017 or 0xF00-0xF04. This covers offsets 0x001, 0x018 (status) and 0x024 (FIFO).
- R5: The access register (offset 0x000) reads with bit 7 always 1. Bit 5 is 1 when the addressed locality is active. Bit 1 is 1 when that locality has a pending request. All other bits read 0.
- R6: Writing bit 1 of a locality's access register while that locality is not active makes it pending. When no locality is active, a pending locality becomes active one cycle after it is pending, and its pending flag clears.
- R7: Writing bit 5 of the active locality's access register releases it. The same write from a locality that is not active has no effect.
- R8: When several localities are pending and none is active, the highest-numbered one is granted.
- R9: Writes to the enable (0x008-0x00B), vector (0x00C-0x00F) and status (0x010-0x013) registers are accepted only from the active locality. Reads are allowed from any locality 0 to 4. Only enable bits 0, 1, 2 and 7 at 0x008 can be stored. The global enable is bit 7 of byte 0x00B. The vector is the low 4 bits of 0x00C, and `irq_num_o` always equals it.
- R10: Status bit 2 (at 0x010) is set on every locality grant. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: `irq_o` is high exactly when the global enable is set and some status bit has its matching enable bit set.
- R12: Read-only identity bytes are little-endian. Capability 0x014-0x017 reads 0x00000497. Device/vendor 0xF00-0xF03 reads 0x1A2BC0DE. Revision 0xF04 reads 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Host bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Locality (15:12) and register offset (11:0) |
| data_io | inout | 8 | Shared data bus: driven by the host on writes, by the block on reads |
| wr_stb_i | input | 1 | Write valid; host data is on `data_io` |
| wr_done_o | output | 1 | Write accepted |
| rd_req_i | input | 1 | Read request for `addr_i` |
| rd_valid_o | output | 1 | Read data is on `data_io` |
| irq_num_o | output | 4 | IRQ number from the vector register |
| irq_o | output | 1 | Interrupt level toward serial interrupt logic |

## Verification
The handshake assertions assume the host never raises `wr_stb_i` and `rd_req_i` together. They also assume the host holds `addr_i` steady while a strobe is up. The directed tasks keep to both: each task raises one strobe, waits for the answer, then drops the strobe and lets the answer fall before the next transfer starts. The locality assertions need no input assumptions. The stimulus still steps through single requests, stacked requests and releases from both active and inactive localities, so that each grant path is exercised.

// File: rtl/tpmrf_pkg.sv
package tpmrf_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ACCESS,
    SEL_INTEN,
    SEL_VEC,
    SEL_STAT,
    SEL_CAP,
    SEL_IDENT,
    SEL_REV
  } reg_sel_e;

  // word index = offset[11:2]
  localparam logic [9:0] W_ACCESS = 10'h000;
  localparam logic [9:0] W_INTEN  = 10'h002;
  localparam logic [9:0] W_VEC    = 10'h003;
  localparam logic [9:0] W_STAT   = 10'h004;
  localparam logic [9:0] W_CAP    = 10'h005;
  localparam logic [9:0] W_IDENT  = 10'h3C0;
  localparam logic [9:0] W_REV    = 10'h3C1;

  localparam int ACC_VALID_BIT = 7;
  localparam int ACC_ACTIVE_BIT = 5;
  localparam int ACC_REQ_BIT = 1;
  localparam int STAT_LOCCHG_BIT = 2;
endpackage

// File: rtl/tpmrf_decode.sv
module tpmrf_decode
  import tpmrf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = $clog2(NUM_LOC)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              loc_ok,
  output logic [LOC_W-1:0]  loc_id,
  output reg_sel_e          sel,
  output logic [1:0]        byte_idx
);
  localparam int FIELD_W = 4;
  logic [FIELD_W-1:0] field;
  logic [9:0]         word;
  logic               b0;

  assign field    = addr[ADDR_W-1 -: FIELD_W];
  assign word     = addr[11:2];
  assign byte_idx = addr[1:0];
  assign b0       = (addr[1:0] == 2'd0);
  assign loc_ok   = (int'(field) < NUM_LOC);
  assign loc_id   = field[LOC_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (loc_ok) begin
      case (word)
        W_ACCESS: sel = b0 ? SEL_ACCESS : SEL_NONE;
        W_INTEN:  sel = SEL_INTEN;
        W_VEC:    sel = SEL_VEC;
        W_STAT:   sel = SEL_STAT;
        W_CAP:    sel = SEL_CAP;
        W_IDENT:  sel = SEL_IDENT;
        W_REV:    sel = b0 ? SEL_REV : SEL_NONE;
        default:  sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tpmrf_handshake.sv
module tpmrf_handshake #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic              rd_req_i,
  input  logic [DATA_W-1:0] rdata_next,
  output logic              wr_done_q,
  output logic              rd_valid_q,
  output logic              wr_fire,
  output logic              bus_oe,
  output logic [DATA_W-1:0] rdata_q
);
  assign wr_fire = wr_stb_i & ~wr_done_q;
  assign bus_oe  = rd_req_i & rd_valid_q & ~wr_stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_done_q  <= 1'b0;
      rd_valid_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      wr_done_q  <= wr_stb_i;
      rd_valid_q <= rd_req_i;
      if (rd_req_i) rdata_q <= rdata_next;
    end
  end
endmodule

// File: rtl/tpmrf_locality.sv
module tpmrf_locality #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = $clog2(NUM_LOC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_wr,
  input  logic [LOC_W-1:0]   wr_loc,
  input  logic               req_bit,
  input  logic               rel_bit,
  output logic [NUM_LOC-1:0] pend_q,
  output logic               act_valid,
  output logic [LOC_W-1:0]   act_id,
  output logic               grant
);
  logic               wr_is_active;
  logic [NUM_LOC-1:0] set_vec, gnt_vec;
  logic [LOC_W-1:0]   pick;
  logic               release_now;

  assign wr_is_active = act_valid && (act_id == wr_loc);
  assign release_now  = acc_wr & rel_bit & wr_is_active;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (pend_q[i]) pick = i[LOC_W-1:0];
    end
  end

  assign grant = ~act_valid & (|pend_q);

  generate
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
      assign set_vec[g] = acc_wr & req_bit & ~wr_is_active & (wr_loc == g[LOC_W-1:0]);
      assign gnt_vec[g] = grant & (pick == g[LOC_W-1:0]);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      act_valid <= 1'b0;
      act_id    <= '0;
    end else begin
      pend_q <= (pend_q | set_vec) & ~gnt_vec;
      if (release_now) begin
        act_valid <= 1'b0;
      end else if (grant) begin
        act_valid <= 1'b1;
        act_id    <= pick;
      end
    end
  end
endmodule

// File: rtl/tpmrf_irq.sv
module tpmrf_irq
  import tpmrf_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          VEC_W     = 4,
  parameter logic [7:0]  EN_MASK   = 8'h87,
  parameter logic [7:0]  STAT_MASK = 8'h87
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_fire,
  input  logic              wr_ok,
  input  reg_sel_e          sel,
  input  logic [1:0]        byte_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              grant,
  output logic [DATA_W-1:0] en_q,
  output logic              glob_q,
  output logic [VEC_W-1:0]  vec_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq_o
);
  logic             wr_gate;
  logic [DATA_W-1:0] clr, setv;

  assign wr_gate = wr_fire & wr_ok & (byte_idx == 2'd0);
  assign clr     = (wr_gate && sel == SEL_STAT) ? wdata : '0;
  assign setv    = grant ? DATA_W'(1 << STAT_LOCCHG_BIT) : '0;
  assign irq_o   = glob_q & (|(stat_q & en_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      glob_q <= 1'b0;
      vec_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_gate && sel == SEL_INTEN) en_q <= wdata & EN_MASK;
      if (wr_fire && wr_ok && sel == SEL_INTEN && byte_idx == 2'd3) glob_q <= wdata[DATA_W-1];
      if (wr_gate && sel == SEL_VEC) vec_q <= wdata[VEC_W-1:0];
      stat_q <= ((stat_q & ~clr) | setv) & STAT_MASK;
    end
  end
endmodule

// File: rtl/tpmrf_top.sv
module tpmrf_top
  import tpmrf_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter int          NUM_LOC = 5,
  parameter int          VEC_W   = 4,
  parameter logic [31:0] CAP_VAL = 32'h0000_0497,
  parameter logic [31:0] ID_VAL  = 32'h1A2B_C0DE,
  parameter logic [7:0]  REV_VAL = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  inout  wire  [DATA_W-1:0] data_io,
  input  logic              wr_stb_i,
  output logic              wr_done_o,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [VEC_W-1:0]  irq_num_o,
  output logic              irq_o
);
  localparam int LOC_W = $clog2(NUM_LOC);

  logic               loc_ok;
  logic [LOC_W-1:0]   loc_id;
  reg_sel_e           sel;
  logic [1:0]         byte_idx;
  logic               wr_fire, bus_oe;
  logic [DATA_W-1:0]  rdata_q, rdata_next;
  logic [NUM_LOC-1:0] pend_q;
  logic               act_valid, grant, wr_ok;
  logic [LOC_W-1:0]   act_id;
  logic [DATA_W-1:0]  en_q, stat_q;
  logic               glob_q;
  logic [VEC_W-1:0]   vec_q;
  logic               mine_act, mine_pend;

  tpmrf_decode #(.ADDR_W(ADDR_W), .NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_dec (
    .addr(addr_i), .loc_ok(loc_ok), .loc_id(loc_id), .sel(sel), .byte_idx(byte_idx)
  );

  tpmrf_handshake #(.DATA_W(DATA_W)) u_hs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb_i(wr_stb_i), .rd_req_i(rd_req_i),
    .rdata_next(rdata_next), .wr_done_q(wr_done_o), .rd_valid_q(rd_valid_o),
    .wr_fire(wr_fire), .bus_oe(bus_oe), .rdata_q(rdata_q)
  );

  tpmrf_locality #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_loc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .acc_wr(wr_fire && sel == SEL_ACCESS),
    .wr_loc(loc_id), .req_bit(data_io[ACC_REQ_BIT]), .rel_bit(data_io[ACC_ACTIVE_BIT]),
    .pend_q(pend_q), .act_valid(act_valid), .act_id(act_id), .grant(grant)
  );

  assign wr_ok = act_valid && (act_id == loc_id);

  tpmrf_irq #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_fire(wr_fire), .wr_ok(wr_ok), .sel(sel),
    .byte_idx(byte_idx), .wdata(data_io), .grant(grant), .en_q(en_q), .glob_q(glob_q),
    .vec_q(vec_q), .stat_q(stat_q), .irq_o(irq_o)
  );

  assign irq_num_o = vec_q;
  assign mine_act  = act_valid && (act_id == loc_id);
  assign mine_pend = pend_q[loc_id];

  always_comb begin
    rdata_next = '0;
    case (sel)
      SEL_ACCESS: begin
        rdata_next[ACC_VALID_BIT]  = 1'b1;
        rdata_next[ACC_ACTIVE_BIT] = mine_act;
        rdata_next[ACC_REQ_BIT]    = mine_pend;
      end
      SEL_INTEN: begin
        if (byte_idx == 2'd0) rdata_next = en_q;
        if (byte_idx == 2'd3) rdata_next[DATA_W-1] = glob_q;
      end
      SEL_VEC:   if (byte_idx == 2'd0) rdata_next[VEC_W-1:0] = vec_q;
      SEL_STAT:  if (byte_idx == 2'd0) rdata_next = stat_q;
      SEL_CAP:   rdata_next = CAP_VAL[8*byte_idx +: 8];
      SEL_IDENT: rdata_next = ID_VAL[8*byte_idx +: 8];
      SEL_REV:   rdata_next = REV_VAL;
      default:   rdata_next = '1;
    endcase
  end

  assign data_io = bus_oe ? rdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/tpmrf_chk.sv
module tpmrf_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = $clog2(NUM_LOC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_stb_i,
  input logic               wr_done_o,
  input logic               rd_req_i,
  input logic               rd_valid_o,
  input logic               bus_oe,
  input logic               act_valid,
  input logic [LOC_W-1:0]   act_id,
  input logic [NUM_LOC-1:0] pend_q,
  input logic [7:0]         stat_q
);
  // R2
  rd_valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);
  // R2
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_req_i || wr_stb_i) |-> !bus_oe);
  // R3
  wr_done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> wr_done_o);
  // R3
  wr_done_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> !wr_done_o);
  // R6
  loc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid |-> (int'(act_id) < NUM_LOC));
  // R7
  no_pend_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid |-> !((pend_q >> act_id) & 1'b1));
  // R10
  grant_sets_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_valid) |-> stat_q[2]);
endmodule

bind tpmrf_top tpmrf_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb_i(wr_stb_i), .wr_done_o(wr_done_o),
  .rd_req_i(rd_req_i), .rd_valid_o(rd_valid_o), .bus_oe(bus_oe),
  .act_valid(act_valid), .act_id(act_id), .pend_q(pend_q), .stat_q(stat_q)
);

// File: tb/sim_tpmrf_top.sv
`timescale 1ns/1ps
module sim_tpmrf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_stb = 1'b0, rd_req = 1'b0, host_oe = 1'b0;
  logic [7:0]  host_d = '0;
  wire  [7:0]  bus;
  logic        wr_done, rd_valid, irq;
  logic [3:0]  irq_num;
  int          n_chk = 0, n_fail = 0;

  assign bus = host_oe ? host_d : 8'hzz;
  always #5 clk = ~clk;

  tpmrf_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_io(bus),
    .wr_stb_i(wr_stb), .wr_done_o(wr_done), .rd_req_i(rd_req),
    .rd_valid_o(rd_valid), .irq_num_o(irq_num), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; host_d = d; host_oe = 1'b1; wr_stb = 1'b1;
    @(negedge clk);
    chk("R3 done rise", wr_done, 1);
    wr_stb = 1'b0; host_oe = 1'b0;
    @(negedge clk);
    chk("R3 done fall", wr_done, 0);
  endtask

  task automatic rd(input string tag, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a; rd_req = 1'b1;
    @(negedge clk);
    chk("R2 valid rise", rd_valid, 1);
    chk(tag, bus, exp);
    rd_req = 1'b0;
    @(negedge clk);
    chk("R2 valid fall", rd_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 wr_done", wr_done, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 irq_num", irq_num, 0);
    for (int l = 0; l < 5; l++) rd("R1 R5 access idle", 16'(l << 12), 8'h80);
    rd("R1 enable", 16'h0008, 8'h00);
    rd("R1 status", 16'h0010, 8'h00);
  endtask

  task automatic t_undef;
    rd("R4 status reg", 16'h0018, 8'hFF);
    rd("R4 fifo reg", 16'h0024, 8'hFF);
    rd("R4 bad locality", 16'h5000, 8'hFF);
    rd("R4 access byte1", 16'h0001, 8'hFF);
    wr(16'h0018, 8'h00);
    rd("R4 status write ignored", 16'h0018, 8'hFF);
    wr(16'h5000, 8'h02);
    for (int l = 0; l < 5; l++) rd("R4 loc5 write ignored", 16'(l << 12), 8'h80);
  endtask

  task automatic t_request;
    wr(16'h2000, 8'h02);
    rd("R6 granted", 16'h2000, 8'hA0);
    rd("R6 other idle", 16'h0000, 8'h80);
    rd("R10 grant sets status", 16'h2010, 8'h04);
  endtask

  task automatic t_priority;
    wr(16'h1000, 8'h02);
    wr(16'h3000, 8'h02);
    rd("R6 loc1 pending", 16'h1000, 8'h82);
    rd("R6 loc3 pending", 16'h3000, 8'h82);
    wr(16'h2000, 8'h20);
    rd("R8 highest wins", 16'h3000, 8'hA0);
    rd("R8 loc1 waits", 16'h1000, 8'h82);
    rd("R7 loc2 released", 16'h2000, 8'h80);
    wr(16'h1000, 8'h20);
    rd("R7 inactive release ignored", 16'h3000, 8'hA0);
  endtask

  task automatic t_irqregs;
    wr(16'h1008, 8'h04);
    rd("R9 inactive write ignored", 16'h3008, 8'h00);
    wr(16'h3008, 8'hFF);
    rd("R9 enable mask", 16'h0008, 8'h87);
    wr(16'h300C, 8'hF9);
    rd("R9 vector", 16'h300C, 8'h09);
    chk("R9 irq_num", irq_num, 4'h9);
    chk("R11 no global", irq, 0);
    wr(16'h300B, 8'h80);
    rd("R9 global readback", 16'h300B, 8'h80);
    chk("R11 irq up", irq, 1);
  endtask

  task automatic t_clear;
    wr(16'h3010, 8'h00);
    rd("R10 zero write keeps", 16'h3010, 8'h04);
    chk("R11 irq held", irq, 1);
    wr(16'h3010, 8'h04);
    rd("R10 cleared", 16'h3010, 8'h00);
    chk("R11 irq down", irq, 0);
  endtask

  task automatic t_ident;
    logic [31:0] cap = 32'h0000_0497, id = 32'h1A2B_C0DE;
    for (int b = 0; b < 4; b++) begin
      rd("R12 capability", 16'h0014 + 16'(b), cap[8*b +: 8]);
      rd("R12 device id", 16'h0F00 + 16'(b), id[8*b +: 8]);
    end
    rd("R12 revision", 16'h4F04, 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_undef;
    t_request;
    t_priority;
    t_irqregs;
    t_clear;
    t_ident;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule